// File: doc/BRIEF.md
# Interrupt Vector Receive Register

This block holds a 64-bit vector of pending interrupts and gives software four ways to reach it through one request port. Hardware sources post an interrupt by presenting a vector number with a valid strobe, and the matching pending bit is set. Software can read the whole vector without changing it. It can also make a priority read, which returns the number of the highest pending vector and clears that bit in the same step. A clear write drops every pending bit that is 1 in the write data.

A fourth access, the dispatch write, does not touch the pending vector. It unpacks a target thread and a vector number from the write data and sends them out as a one-cycle post request for the routing fabric. Every access gets exactly one response on the clock edge that follows it.

Top module: `ivr_top`

## Requirements
- R1: After reset the pending vector is all zeros, and `rsp_valid` and `dsp_valid` are low.
- R2: A cycle with `post_valid` high sets pending bit `post_vec`. The bit is visible to any access made in a later cycle.
- R3: A plain read (`req_kind` = 0) returns the pending vector as it stood in the request cycle, and changes no bit.
- R4: A priority read (`req_kind` = 1) with a non-empty vector returns the index of the most significant pending bit in `rsp_data[5:0]`, with the upper bits zero, and clears that bit.
- R5: A priority read of an empty vector returns 0 and leaves the vector unchanged.
- R6: A clear write (`req_kind` = 2) clears every pending bit whose bit in `req_wdata` is 1, and leaves the other bits as they were.
- R7: If a post and a clear (either a clear write or a priority read) hit the same bit in the same cycle, the bit ends up set.
- R8: A dispatch write (`req_kind` = 3) raises `dsp_valid` for one cycle on the next edge, with `dsp_thread` = `req_wdata[12:8]` and `dsp_vec` = `req_wdata[5:0]`. The pending vector is not changed.
- R9: Each request cycle gives `rsp_valid` high on exactly the next cycle, and a cycle without a request gives no response. Clear and dispatch writes return `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Hardware post strobe |
| post_vec | input | 6 | Vector number to set |
| req_valid | input | 1 | Software access strobe |
| req_kind | input | 2 | 0 read, 1 priority read, 2 clear write, 3 dispatch write |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 64 | Read data |
| dsp_valid | output | 1 | Outgoing post request strobe |
| dsp_thread | output | 5 | Target thread of the outgoing post |
| dsp_vec | output | 6 | Vector number of the outgoing post |

## Verification
A hardware post can arrive in the same cycle as a software clear, either a clear write or a priority read. The bench provokes this on purpose: random clear masks are often forced to cover the vector being posted, and directed cases post the exact bit that a priority read is about to take. A reference model in the bench applies the clears first and the post last, so the posted bit must survive. It then judges the result from the data that later reads return.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  parameter int VEC_W    = 64;
  parameter int IDX_W    = $clog2(VEC_W);
  parameter int THREAD_W = 5;
  localparam int THREAD_LSB = 8;
  localparam int VNUM_LSB   = 0;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_PRIO  = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_SEND  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/ivr_msb_find.sv
module ivr_msb_find #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/ivr_pend_store.sv
module ivr_pend_store #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/ivr_dispatch.sv
module ivr_dispatch #(
  parameter int W   = 64,
  parameter int TW  = 5,
  parameter int IW  = 6,
  parameter int TLSB = 8,
  parameter int VLSB = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [W-1:0]  wdata,
  output logic          out_valid,
  output logic [TW-1:0] out_thread,
  output logic [IW-1:0] out_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_thread <= '0;
      out_vec    <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_thread <= wdata[TLSB +: TW];
        out_vec    <= wdata[VLSB +: IW];
      end
    end
  end
endmodule

// File: rtl/ivr_top.sv
module ivr_top
  import ivr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                post_valid,
  input  logic [IDX_W-1:0]    post_vec,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [VEC_W-1:0]    req_wdata,
  output logic                rsp_valid,
  output logic [VEC_W-1:0]    rsp_data,
  output logic                dsp_valid,
  output logic [THREAD_W-1:0] dsp_thread,
  output logic [IDX_W-1:0]    dsp_vec
);
  acc_kind_e        kind;
  logic [VEC_W-1:0] pend_q;
  logic [VEC_W-1:0] clr_mask;
  logic [VEC_W-1:0] set_mask;
  logic             top_any;
  logic [IDX_W-1:0] top_idx;
  logic [VEC_W-1:0] rdata_d;

  assign kind = acc_kind_e'(req_kind);

  ivr_msb_find #(.W(VEC_W), .IW(IDX_W)) u_find (
    .vec(pend_q), .any(top_any), .idx(top_idx)
  );

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    rdata_d  = '0;
    if (req_valid) begin
      case (kind)
        ACC_READ:  rdata_d = pend_q;
        ACC_PRIO: begin
          rdata_d = {{(VEC_W-IDX_W){1'b0}}, top_idx};
          if (top_any) clr_mask[top_idx] = 1'b1;
        end
        ACC_CLEAR: clr_mask = req_wdata;
        default:   rdata_d = '0;
      endcase
    end
    if (post_valid) set_mask[post_vec] = 1'b1;
  end

  ivr_pend_store #(.W(VEC_W)) u_store (
    .clk(clk), .rst(rst), .clr_mask(clr_mask), .set_mask(set_mask), .pend_q(pend_q)
  );

  ivr_dispatch #(
    .W(VEC_W), .TW(THREAD_W), .IW(IDX_W), .TLSB(THREAD_LSB), .VLSB(VNUM_LSB)
  ) u_disp (
    .clk(clk), .rst(rst), .fire(req_valid && kind == ACC_SEND), .wdata(req_wdata),
    .out_valid(dsp_valid), .out_thread(dsp_thread), .out_vec(dsp_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= rdata_d;
    end
  end
endmodule

// File: rtl/ivr_chk.sv
module ivr_chk
  import ivr_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                post_valid,
  input logic [IDX_W-1:0]    post_vec,
  input logic                req_valid,
  input logic [1:0]          req_kind,
  input logic [VEC_W-1:0]    req_wdata,
  input logic                rsp_valid,
  input logic [VEC_W-1:0]    rsp_data,
  input logic                dsp_valid,
  input logic [THREAD_W-1:0] dsp_thread,
  input logic [IDX_W-1:0]    dsp_vec,
  input logic [VEC_W-1:0]    pend
);
  p_post_sets_r2: assert property (@(posedge clk) disable iff (rst)
    post_valid |=> pend[$past(post_vec)]);

  p_read_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd0 && !post_valid) |=> $stable(pend));

  p_empty_prio_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1 && pend == '0) |=> rsp_data == '0);

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd2 && !post_valid) |=> (pend & $past(req_wdata)) == '0);

  p_dispatch_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |=>
      (dsp_valid && dsp_thread == $past(req_wdata[12:8]) && dsp_vec == $past(req_wdata[5:0])));

  p_no_dispatch_r8: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_kind == 2'd3) |=> !dsp_valid);

  p_resp_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_resp_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind ivr_top ivr_chk u_chk (
  .clk(clk), .rst(rst), .post_valid(post_valid), .post_vec(post_vec),
  .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dsp_valid(dsp_valid),
  .dsp_thread(dsp_thread), .dsp_vec(dsp_vec), .pend(pend_q)
);

// File: tb/tb_ivr_top.sv
`timescale 1ns/1ps
module tb_ivr_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        post_valid;
  logic [5:0]  post_vec;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        dsp_valid;
  logic [4:0]  dsp_thread;
  logic [5:0]  dsp_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] model = '0;

  always #2 clk = ~clk;

  ivr_top dut (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_vec(post_vec),
    .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dsp_valid(dsp_valid),
    .dsp_thread(dsp_thread), .dsp_vec(dsp_vec)
  );

  function automatic int top_bit(input logic [63:0] v);
    for (int i = 63; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check the registered results at the next one.
  task automatic step(input bit pv, input logic [5:0] pvec, input bit rv,
                      input logic [1:0] k, input logic [63:0] wd);
    logic [63:0] exp_data;
    logic [63:0] nxt;
    string tag;
    int t;
    post_valid = pv; post_vec = pvec; req_valid = rv; req_kind = k; req_wdata = wd;
    nxt = model; exp_data = '0; tag = "R9";
    t = top_bit(model);
    if (rv) begin
      case (k)
        2'd0: begin exp_data = model; tag = "R3 (bits from R2 posts)"; end
        2'd1: begin
          if (t < 0) tag = "R5";
          else begin
            exp_data = 64'(t); nxt[t] = 1'b0;
            tag = (pv && pvec == t[5:0]) ? "R7" : "R4";
          end
        end
        2'd2: begin
          nxt = model & ~wd;
          tag = (pv && wd[pvec]) ? "R7" : "R6";
        end
        default: tag = "R8";
      endcase
    end
    if (pv) nxt[pvec] = 1'b1;
    @(negedge clk);
    chk("R9 rsp_valid", 64'(rsp_valid), 64'(rv));
    if (rv) chk({tag, " rsp_data"}, rsp_data, exp_data);
    chk("R8 dsp_valid", 64'(dsp_valid), 64'(rv && k == 2'd3));
    if (rv && k == 2'd3) begin
      chk("R8 dsp_thread", 64'(dsp_thread), 64'(wd[12:8]));
      chk("R8 dsp_vec", 64'(dsp_vec), 64'(wd[5:0]));
    end
    model = nxt;
    post_valid = 0; req_valid = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    rst = 1; post_valid = 0; post_vec = 0; req_valid = 0; req_kind = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 dsp_valid", 64'(dsp_valid), 64'd0);
    step(0, 0, 1, 2'd0, 0);                 // R1: vector empty after reset
    step(0, 0, 1, 2'd1, 0);                 // R5: empty priority read
    step(0, 0, 1, 2'd0, 0);                 // R5: still empty
    step(1, 6'd63, 0, 0, 0);                // R2
    step(1, 6'd0, 0, 0, 0);
    step(1, 6'd17, 1, 2'd0, 0);             // R3 read with concurrent post
    step(0, 0, 1, 2'd1, 0);                 // R4 returns 63
    step(1, 6'd17, 1, 2'd1, 0);             // R7 priority read vs post of 17
    step(0, 0, 1, 2'd0, 0);                 // 17 must survive
    step(1, 6'd5, 1, 2'd2, 64'h1_0000_0021);// R7 clear write vs post of 5
    step(0, 0, 1, 2'd0, 0);
    step(0, 0, 1, 2'd3, 64'h1F3F);          // R8 all-ones fields
    step(0, 0, 1, 2'd0, 0);                 // R8 leaves vector alone
    step(0, 0, 1, 2'd2, '1);                // R6 clear everything
    step(0, 0, 1, 2'd1, 0);                 // R5
    for (int n = 0; n < 3000; n++) begin
      bit pv, rv;
      logic [5:0] pvec;
      logic [1:0] k;
      logic [63:0] wd;
      pv = ($urandom % 10) < 4;
      pvec = 6'($urandom);
      rv = ($urandom % 10) < 6;
      k = 2'($urandom);
      wd = {$urandom, $urandom} & {$urandom, $urandom};
      if (k == 2'd2 && ($urandom % 3) == 0) wd[pvec] = 1'b1;
      step(pv, pvec, rv, k, wd);
    end
    step(0, 0, 1, 2'd0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule